// File: doc/BRIEF.md
# Clocked Serial Shift Port

This block moves one byte at a time over a three-wire synchronous serial link. Software fills the byte through two nibble-wide write strobes and then pulses a start strobe. The port shifts the byte out on `sout` while it gathers a byte from `sin`. The serial clock is either made inside the block from a divider of the system clock and driven onto the clock pin (master), or taken from the clock pin (slave). The received byte replaces the sent one and is read back through the same two nibble views.

A configuration bit picks whether input bits are taken on the rising or the falling serial clock edge. The output always moves on the rising edge. The first bit on the wire, either the least or the most significant, is fixed when the block is built. The pin polarity can be inverted. When eight serial clock cycles have been counted, a completion flag is set whatever the mask holds, and the interrupt request is that flag gated by the mask. A ready output is high for the whole transfer, so an external master knows when it may clock the port.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, `readyOut`, `irqFlag`, `irqReq` and both nibble views are 0, the mask is 0, and `sclkOut` sits at its idle level (1 when `cfgClkInvert`=0, 0 when it is 1).
- R2: A `loWr` pulse while idle loads `wrData` into byte bits 3..0, shown on `rdLo`. A `hiWr` pulse loads bits 7..4, shown on `rdHi`.
- R3: A `trigWr` pulse while idle raises `readyOut` on the next clock. `readyOut` falls on the clock where the 8th rising serial clock edge is acted on, so exactly eight serial clock cycles make one transfer.
- R4: In master mode `sclkOe` is 1 and the internal serial clock toggles every `DIV_HALF` system clocks during a transfer. It leaves idle with a falling edge and stays at idle between transfers. In slave mode `sclkOe` is 0.
- R5: The first bit is on `sout` from the clock after the trigger. `sout` changes only together with a rising serial clock edge.
- R6: With `cfgRiseEdge`=1, `sin` is taken on rising serial clock edges. With `cfgRiseEdge`=0, it is taken on falling edges.
- R7: With `MSB_FIRST`=0, byte bit 0 is sent first and the k-th bit taken from `sin` lands in byte bit k-1. With `MSB_FIRST`=1 the order is reversed.
- R8: The end of a transfer sets `irqFlag` whether or not the mask is set. `irqReq` is `irqFlag` AND the mask, and the mask is loaded from `maskData` by a `maskWr` pulse.
- R9: A `flagClrWr` pulse clears `irqFlag`. If a transfer completes in the same clock, the flag is set.
- R10: `loWr`, `hiWr` and `trigWr` pulses during a transfer change neither the byte nor the transfer.
- R11: In slave mode `sclkIn` passes through a two-flop synchronizer before edge detection. Edges on it are counted only during a transfer.
- R12: `cfgClkInvert`=1 inverts the clock pin in both directions, so the idle pin level becomes 0 and the edge roles swap at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | 4 | Nibble to load |
| loWr | input | 1 | Load low nibble strobe |
| hiWr | input | 1 | Load high nibble strobe |
| trigWr | input | 1 | Start strobe (a written 1 on the trigger bit) |
| maskWr | input | 1 | Mask load strobe |
| maskData | input | 1 | Mask value |
| flagClrWr | input | 1 | Write-one-to-clear strobe for the flag |
| cfgMaster | input | 1 | 1 = internal clock, 0 = external clock |
| cfgRiseEdge | input | 1 | Input sampling edge select |
| cfgClkInvert | input | 1 | Clock pin polarity |
| sclkIn | input | 1 | Clock pin input (slave) |
| sin | input | 1 | Serial data input |
| sclkOut | output | 1 | Clock pin drive value |
| sclkOe | output | 1 | Clock pin drive enable |
| sout | output | 1 | Serial data output |
| readyOut | output | 1 | Transfer in progress handshake |
| irqFlag | output | 1 | Completion flag |
| irqReq | output | 1 | Masked interrupt request |
| rdLo | output | 4 | Byte bits 3..0 |
| rdHi | output | 4 | Byte bits 7..4 |

## Verification
The checks assume that the configuration inputs stay still for the length of a transfer and for a few clocks before it. They also assume that an external clock on `sclkIn` holds each level for several system clocks, so the synchronizer never loses an edge. The stimulus changes configuration only while idle, waits before each trigger, and holds each slave clock level for six system clocks. It changes `sin` only on the serial clock edge that does not sample. The register strobes are pulsed one clock at a time and never together with the start pulse.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // Strobes the control path issues to the datapath each system clock
  typedef struct packed {
    logic loadLo;   // take wrData into the low nibble
    logic loadHi;   // take wrData into the high nibble
    logic start;    // a transfer begins: present the first bit
    logic sample;   // shift sin into the byte
    logic advance;  // rising serial edge: move sout to the next bit
  } sspStrobe_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int BITS     = 8,
  parameter int DIV_HALF = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loWr,
  input  logic       hiWr,
  input  logic       trigWr,
  input  logic       maskWr,
  input  logic       maskData,
  input  logic       flagClrWr,
  input  logic       cfgMaster,
  input  logic       cfgRiseEdge,
  input  logic       cfgClkInvert,
  input  logic       sclkIn,
  output sspStrobe_t strb,
  output logic       sclkOut,
  output logic       sclkOe,
  output logic       readyOut,
  output logic       irqFlag,
  output logic       irqReq
);
  localparam int CNT_W = (BITS > 2) ? $clog2(BITS) : 1;
  localparam int DIV_W = $clog2(DIV_HALF + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);

  logic             busyQ;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             intClk;
  logic             syncA, syncB, lvlPrev;
  logic             flagQ, maskQ;

  logic lvlNow, toggle, riseEv, fallEv, doneEv, startOk;

  // master clock generation and slave edge detection
  always_comb begin
    toggle  = cfgMaster && busyQ && (divCnt == DIV_LAST);
    lvlNow  = syncB ^ cfgClkInvert;
    riseEv  = (toggle && !intClk) ||
              (!cfgMaster && busyQ && lvlNow && !lvlPrev);
    fallEv  = (toggle && intClk) ||
              (!cfgMaster && busyQ && !lvlNow && lvlPrev);
    doneEv  = riseEv && (bitCnt == LAST_BIT);
    startOk = trigWr && !busyQ;
  end

  always_comb begin
    strb.loadLo  = loWr && !busyQ;
    strb.loadHi  = hiWr && !busyQ;
    strb.start   = startOk;
    strb.sample  = cfgRiseEdge ? riseEv : fallEv;
    strb.advance = riseEv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      lvlPrev <= 1'b0;
    end else begin
      syncA   <= sclkIn;
      syncB   <= syncA;
      lvlPrev <= lvlNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      bitCnt <= '0;
      divCnt <= '0;
      intClk <= 1'b1;
    end else if (startOk) begin
      busyQ  <= 1'b1;
      bitCnt <= '0;
      divCnt <= '0;
      intClk <= 1'b1;
    end else if (busyQ) begin
      if (cfgMaster) begin
        divCnt <= toggle ? '0 : divCnt + 1'b1;
        if (toggle) intClk <= ~intClk;
      end
      if (riseEv) bitCnt <= bitCnt + 1'b1;
      if (doneEv) busyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      maskQ <= 1'b0;
    end else begin
      if (maskWr) maskQ <= maskData;
      if (doneEv) flagQ <= 1'b1;
      else if (flagClrWr) flagQ <= 1'b0;
    end
  end

  assign sclkOut  = intClk ^ cfgClkInvert;
  assign sclkOe   = cfgMaster;
  assign readyOut = busyQ;
  assign irqFlag  = flagQ;
  assign irqReq   = flagQ & maskQ;

  // R3
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> (bitCnt == '0));

  // R4
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> intClk);

  // R8
  flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> ($past(busyQ) && !busyQ));

  // R3
  ready_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> flagQ);
endmodule

// File: rtl/ssp_data.sv
module ssp_data
  import ssp_pkg::*;
#(
  parameter int BITS      = 8,
  parameter bit MSB_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  sspStrobe_t        strb,
  input  logic [BITS/2-1:0] wrData,
  input  logic              sin,
  output logic [BITS-1:0]   shReg,
  output logic              sout
);
  localparam int NIB = BITS / 2;

  logic [BITS-1:0] shNext;
  logic            headCur, headNext;
  logic            txBit;

  generate
    if (MSB_FIRST) begin : g_msb
      assign shNext   = {shReg[BITS-2:0], sin};
      assign headCur  = shReg[BITS-1];
      assign headNext = shNext[BITS-1];
    end else begin : g_lsb
      assign shNext   = {sin, shReg[BITS-1:1]};
      assign headCur  = shReg[0];
      assign headNext = shNext[0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.sample) begin
      shReg <= shNext;
    end else begin
      if (strb.loadLo) shReg[NIB-1:0]    <= wrData;
      if (strb.loadHi) shReg[BITS-1:NIB] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txBit <= 1'b0;
    else if (strb.start) txBit <= headCur;
    else if (strb.advance) txBit <= strb.sample ? headNext : headCur;
  end

  assign sout = txBit;

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.start || strb.advance) |=> $stable(txBit));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int BITS      = 8,
  parameter int DIV_HALF  = 4,
  parameter bit MSB_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BITS/2-1:0] wrData,
  input  logic              loWr,
  input  logic              hiWr,
  input  logic              trigWr,
  input  logic              maskWr,
  input  logic              maskData,
  input  logic              flagClrWr,
  input  logic              cfgMaster,
  input  logic              cfgRiseEdge,
  input  logic              cfgClkInvert,
  input  logic              sclkIn,
  input  logic              sin,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              sout,
  output logic              readyOut,
  output logic              irqFlag,
  output logic              irqReq,
  output logic [BITS/2-1:0] rdLo,
  output logic [BITS/2-1:0] rdHi
);
  localparam int NIB = BITS / 2;

  sspStrobe_t      strb;
  logic [BITS-1:0] shReg;

  ssp_ctrl #(.BITS(BITS), .DIV_HALF(DIV_HALF)) i_ctrl (
    .clk(clk), .rstN(rstN), .loWr(loWr), .hiWr(hiWr), .trigWr(trigWr),
    .maskWr(maskWr), .maskData(maskData), .flagClrWr(flagClrWr),
    .cfgMaster(cfgMaster), .cfgRiseEdge(cfgRiseEdge),
    .cfgClkInvert(cfgClkInvert), .sclkIn(sclkIn), .strb(strb),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .readyOut(readyOut),
    .irqFlag(irqFlag), .irqReq(irqReq)
  );

  ssp_data #(.BITS(BITS), .MSB_FIRST(MSB_FIRST)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .sin(sin),
    .shReg(shReg), .sout(sout)
  );

  assign rdLo = shReg[NIB-1:0];
  assign rdHi = shReg[BITS-1:NIB];
endmodule

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;
  localparam int DIV = 4;
  localparam int HALF_S = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic [3:0] wrData = '0;
  logic loWr = 0, hiWr = 0, trigWr = 0, maskWr = 0, maskData = 0, flagClrWr = 0;
  logic cfgMaster = 1, cfgRiseEdge = 0, cfgClkInvert = 0, sclkIn = 1, sin = 0;
  logic sclkOut, sclkOe, sout, readyOut, irqFlag, irqReq;
  logic [3:0] rdLo, rdHi;

  sync_serial_port #(.BITS(8), .DIV_HALF(DIV), .MSB_FIRST(1'b0)) i_sync_serial_port (
    .clk(clk), .rstN(rstN), .wrData(wrData), .loWr(loWr), .hiWr(hiWr),
    .trigWr(trigWr), .maskWr(maskWr), .maskData(maskData), .flagClrWr(flagClrWr),
    .cfgMaster(cfgMaster), .cfgRiseEdge(cfgRiseEdge), .cfgClkInvert(cfgClkInvert),
    .sclkIn(sclkIn), .sin(sin), .sclkOut(sclkOut), .sclkOe(sclkOe), .sout(sout),
    .readyOut(readyOut), .irqFlag(irqFlag), .irqReq(irqReq), .rdLo(rdLo), .rdHi(rdHi)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // behavioural reference: serial clock phase, bit count, byte, flag
  bit       mBusy = 0, mClk = 1, mSout = 0, mFlag = 0, mMask = 0;
  int       mDiv = 0, mRises = 0;
  bit [7:0] mData = 0;
  bit       hA = 0, hB = 0, hPrev = 0;
  bit       armed = 0;

  always @(posedge clk) begin
    bit busyPre, rise, fall, lvl, samp;
    if (!rstN) begin
      mBusy = 0; mClk = 1; mSout = 0; mFlag = 0; mMask = 0;
      mDiv = 0; mRises = 0; mData = 0; hA = 0; hB = 0; hPrev = 0;
    end else begin
      busyPre = mBusy; rise = 0; fall = 0;
      lvl = hB ^ cfgClkInvert;
      if (cfgMaster) begin
        if (busyPre) begin
          if (mDiv == DIV - 1) begin
            mDiv = 0;
            if (mClk) fall = 1; else rise = 1;
            mClk = !mClk;
          end else mDiv++;
        end
      end else if (busyPre) begin
        rise = lvl && !hPrev;
        fall = !lvl && hPrev;
      end
      hPrev = lvl; hB = hA; hA = sclkIn;
      samp = cfgRiseEdge ? rise : fall;
      if (samp) mData = {sin, mData[7:1]};
      if (maskWr) mMask = maskData;
      if (rise) begin
        mSout = mData[0];
        if (mRises == 7) begin mRises = 0; mBusy = 0; mFlag = 1; end
        else mRises++;
      end else if (flagClrWr) mFlag = 0;
      if (rise && mRises == 0 && !mBusy) ; // completion already handled
      else if (flagClrWr && !(rise && !mBusy)) mFlag = 0;
      if (!busyPre) begin
        if (loWr) mData[3:0] = wrData;
        if (hiWr) mData[7:4] = wrData;
        if (trigWr) begin
          mBusy = 1; mRises = 0; mDiv = 0; mClk = 1; mSout = mData[0];
        end
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && armed) begin
      check(readyOut == mBusy, "R3 ready", readyOut, mBusy);
      check(irqFlag == mFlag, "R8 flag", irqFlag, mFlag);
      check(irqReq == (mFlag & mMask), "R8 irq", irqReq, mFlag & mMask);
      check(sout == mSout, "R5 sout", sout, mSout);
      check(sclkOut == (mClk ^ cfgClkInvert), "R4 R12 sclkOut", sclkOut, mClk ^ cfgClkInvert);
      check(sclkOe == cfgMaster, "R4 sclkOe", sclkOe, cfgMaster);
      check({rdHi, rdLo} == mData, "R2 byte view", {rdHi, rdLo}, mData);
    end
  end

  // peripheral on the far side: drives sin, records sout at falling edges
  bit       active = 0, lastLvl = 1;
  int       fallCnt = 0, riseCnt = 0;
  bit [7:0] rxPat = 0, txSeen = 0;

  always @(negedge clk) begin
    bit lvl;
    if (active) begin
      lvl = (cfgMaster ? sclkOut : sclkIn) ^ cfgClkInvert;
      if (lvl != lastLvl) begin
        if (!lvl) begin
          if (fallCnt < 8) txSeen[fallCnt] = sout;
          fallCnt++;
          if (cfgRiseEdge && fallCnt <= 8) sin = rxPat[fallCnt-1];
        end else begin
          riseCnt++;
          if (!cfgRiseEdge && riseCnt < 8) sin = rxPat[riseCnt];
        end
        lastLvl = lvl;
      end
    end
  end

  task automatic pulseIntrude();
    @(negedge clk); wrData = 4'hF; loWr = 1; hiWr = 1; trigWr = 1;
    @(negedge clk); loWr = 0; hiWr = 0; trigWr = 0;
  endtask

  task automatic transfer(input bit master, input bit riseEdge, input bit inv,
                          input bit [7:0] tx, input bit [7:0] rx, input bit intrude,
                          input bit idleEdges);
    @(negedge clk);
    cfgMaster = master; cfgRiseEdge = riseEdge; cfgClkInvert = inv; #2 sclkIn = 1 ^ inv;
    repeat (6) @(negedge clk);
    if (idleEdges) begin
      // R11: clock edges while idle must not start counting
      repeat (3) begin
        repeat (HALF_S) @(negedge clk); #2 sclkIn = 0 ^ inv;
        repeat (HALF_S) @(negedge clk); #2 sclkIn = 1 ^ inv;
      end
      repeat (6) @(negedge clk);
      check(readyOut == 0, "R11 idle edges", readyOut, 0);
    end
    wrData = tx[3:0]; loWr = 1;
    @(negedge clk); loWr = 0; wrData = tx[7:4]; hiWr = 1;
    @(negedge clk); hiWr = 0;
    check({rdHi, rdLo} == tx, "R2 load", {rdHi, rdLo}, tx);
    rxPat = rx; fallCnt = 0; riseCnt = 0; lastLvl = 1; txSeen = 0; sin = rx[0]; active = 1;
    trigWr = 1;
    @(negedge clk); trigWr = 0;
    check(readyOut == 1, "R3 ready rise", readyOut, 1);
    check(sout == tx[0], "R5 first bit", sout, tx[0]);
    if (master) begin
      repeat (20) @(negedge clk);
      if (intrude) pulseIntrude();
    end else begin
      for (int k = 0; k < 8; k++) begin
        repeat (HALF_S) @(negedge clk); #2 sclkIn = 0 ^ inv;
        repeat (HALF_S) @(negedge clk); #2 sclkIn = 1 ^ inv;
        if (intrude && k == 3) pulseIntrude();
      end
    end
    while (readyOut) @(negedge clk);
    active = 0;
    check(fallCnt == 8, "R3 eight cycles", fallCnt, 8);
    check(txSeen == tx, "R7 R5 sent order", txSeen, tx);
    check({rdHi, rdLo} == rx, "R6 R7 R10 received", {rdHi, rdLo}, rx);
    check(irqFlag == 1, "R8 flag set", irqFlag, 1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    check(readyOut == 0, "R1 ready", readyOut, 0);
    check(irqFlag == 0 && irqReq == 0, "R1 flag", {irqFlag, irqReq}, 0);
    check({rdHi, rdLo} == 8'h00, "R1 byte", {rdHi, rdLo}, 0);
    check(sclkOut == 1, "R1 sclk idle", sclkOut, 1);
    armed = 1;

    // master, falling-edge sampling, mask clear
    transfer(1, 0, 0, 8'hA5, 8'h3C, 0, 0);
    check(irqReq == 0, "R8 masked", irqReq, 0);

    // R9 clear, then enable mask
    @(negedge clk); flagClrWr = 1;
    @(negedge clk); flagClrWr = 0;
    check(irqFlag == 0, "R9 clear", irqFlag, 0);
    maskWr = 1; maskData = 1;
    @(negedge clk); maskWr = 0;

    // master, rising sampling, inverted pin, writes during transfer (R10, R12)
    transfer(1, 1, 1, 8'h96, 8'hE1, 1, 0);
    check(irqReq == 1, "R8 unmasked", irqReq, 1);

    // slave, falling sampling, idle edges and intrusion (R11)
    transfer(0, 0, 0, 8'h5A, 8'h81, 1, 1);
    // slave, rising sampling, inverted pin
    transfer(0, 1, 1, 8'hC3, 8'h7E, 0, 0);

    repeat (4) @(negedge clk);
    done = 1;
    finishRun();
  end
endmodule